// File: doc/BRIEF.md
# Oversampling Serial Receiver with Status Flags

This block recovers asynchronous serial characters from a single receive line. A tick input, pulsed once for every sixteenth of a bit period, paces all of its timing. A falling edge on the synchronised line starts a start-bit check. Each bit is then judged from three mid-bit samples. A completed character of 8 or 9 data bits, sent least significant bit first, is placed in a receive holding register. The block shows that register to the host as a valid/ready output stream.

Next to the data it keeps four sticky flags: overrun, noise, framing error and idle line. It also drives one interrupt request, which is the OR of three gated sources: data available, overrun and idle. `out_valid` is the receive-full flag. While valid is high and ready is low, the data holds. A character is consumed in a cycle where both are high. The error and idle flags clear by a two-step sequence. First the host pulses `stat_rd`. Then a later cycle with `out_ready` high clears the flags.

Top module: `serial_rx_flags`

## Requirements
- R1: Each bit lasts 16 ticks, counted from the first tick that sees the line low after a tick that saw it high. The line is sampled at ticks 8, 9 and 10 of each bit, and the majority of the three samples is the bit value. Data bits arrive least significant first.
- R2: If the majority of the start-bit samples is 1, the start is dropped. The receiver goes back to hunting for an edge, and no character is produced.
- R3: If the three samples of any bit of a character disagree (start, data or stop bit), `flag_noise` is set in the same cycle that the character is loaded and `out_valid` rises.
- R4: If the majority of the stop-bit samples is 0, `flag_frame` is set in the same cycle that the character is loaded.
- R5: When a character is loaded, `out_valid` goes high. In 9-bit mode (`word9`=1) `out_data` carries bits [8:0]. In 8-bit mode it carries bits [7:0] and bit 8 reads 0. Valid and data hold until a cycle with `out_valid` and `out_ready` both high, after which `out_valid` is 0.
- R6: A character that completes while `out_valid` is high and is not being consumed in that cycle sets `flag_overrun`. The held data is kept. The new character is discarded, and its noise and framing results are dropped with it.
- R7: `flag_idle` sets after 160 consecutive high tick samples in 8-bit mode, or after 176 in 9-bit mode (10 or 11 bit periods).
- R8: The idle flag can set only once for each received character. It is disarmed after reset and re-armed when a character completes.
- R9: `irq` = (`out_valid` & `ie_full`) | (`flag_overrun` & `ie_overrun`) | (`flag_idle` & `ie_idle`).
- R10: A `stat_rd` pulse arms the clear. The next cycle with `out_ready` high clears overrun, noise, framing and idle, and disarms the clear. An `out_ready` cycle with no `stat_rd` before it leaves those flags unchanged.
- R11: After reset, `out_valid`, all four flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx | input | 1 | Asynchronous serial line, idle high |
| word9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| ie_full | input | 1 | Interrupt enable for data available |
| ie_overrun | input | 1 | Interrupt enable for overrun |
| ie_idle | input | 1 | Interrupt enable for idle line |
| stat_rd | input | 1 | Status read strobe; arms the flag clear |
| out_ready | input | 1 | Host accepts data (data read strobe) |
| out_valid | output | 1 | Receive holding register full |
| out_data | output | DATA_W | Received character |
| flag_overrun | output | 1 | Overrun flag |
| flag_noise | output | 1 | Noise flag |
| flag_frame | output | 1 | Framing error flag |
| flag_idle | output | 1 | Idle line flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions rely on three things about the inputs. `tick16` is a single-cycle pulse, spaced further apart than the synchroniser depth. `word9` stays still while a character is in flight. The line changes no faster than once per tick. The stimulus meets all three. It derives the tick from a free-running divide-by-four, and it changes `rx` only on the falling clock edge of a tick cycle. It changes `word9` only at the start of a character, and it places any noise glitch as a one-tick inversion at the middle sample of a bit, so each glitch flips exactly one of the three samples.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_t;

  // value of a bit from three samples
  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // samples that do not all agree
  function automatic logic split3(input logic [2:0] s);
    return (s != 3'b000) && (s != 3'b111);
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = q[STAGES-1];

endmodule

// File: rtl/srx_deser.sv
module srx_deser
  import srx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxs,
  input  logic              word9,
  output logic              done,
  output logic [DATA_W-1:0] dout,
  output logic              d_noise,
  output logic              d_frame
);

  localparam int PW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [PW-1:0] PH_A   = PW'(OVS/2 - 1);
  localparam logic [PW-1:0] PH_B   = PW'(OVS/2);
  localparam logic [PW-1:0] PH_C   = PW'(OVS/2 + 1);
  localparam logic [PW-1:0] PH_END = PW'(OVS - 1);
  localparam logic [BW-1:0] IDX_LONG  = BW'(DATA_W - 1);
  localparam logic [BW-1:0] IDX_SHORT = BW'(DATA_W - 2);

  rx_state_t         st;
  logic [PW-1:0]     ph;
  logic [BW-1:0]     bitn;
  logic [1:0]        smp;
  logic [DATA_W-1:0] shr;
  logic              nacc;
  logic              last;
  logic              w9;

  logic [2:0] trio;
  logic       bit_v;
  logic       bit_n;
  logic [BW-1:0] idx_end;

  always_comb begin
    trio    = {smp, rxs};
    bit_v   = maj3(trio);
    bit_n   = split3(trio);
    idx_end = w9 ? IDX_LONG : IDX_SHORT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_HUNT;
      ph      <= '0;
      bitn    <= '0;
      smp     <= '0;
      shr     <= '0;
      nacc    <= 1'b0;
      last    <= 1'b1;
      w9      <= 1'b0;
      done    <= 1'b0;
      dout    <= '0;
      d_noise <= 1'b0;
      d_frame <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        last <= rxs;
        if (st == ST_HUNT) begin
          if (last && !rxs) begin
            st   <= ST_START;
            ph   <= '0;
            nacc <= 1'b0;
            w9   <= word9;
          end
        end else begin
          ph <= (ph == PH_END) ? '0 : ph + 1'b1;
          if (ph == PH_A || ph == PH_B) smp <= {smp[0], rxs};
          if (ph == PH_C) begin
            case (st)
              ST_START: begin
                if (bit_v) begin
                  st <= ST_HUNT;
                end else begin
                  nacc <= bit_n;
                  bitn <= '0;
                  st   <= ST_DATA;
                end
              end
              ST_DATA: begin
                shr  <= {bit_v, shr[DATA_W-1:1]};
                nacc <= nacc | bit_n;
                bitn <= bitn + 1'b1;
                if (bitn == idx_end) st <= ST_STOP;
              end
              ST_STOP: begin
                done    <= 1'b1;
                dout    <= w9 ? shr : {1'b0, shr[DATA_W-1:1]};
                d_noise <= nacc | bit_n;
                d_frame <= !bit_v;
                st      <= ST_HUNT;
              end
              default: st <= ST_HUNT;
            endcase
          end
        end
      end
    end
  end

  // a finished character is only reported on the cycle after a tick
  AST_DONE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(tick)); // R1

  // leaving the start check always follows a decision tick
  AST_START_DECIDED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_START && st != ST_START) |-> $past(tick)); // R2

endmodule

// File: rtl/srx_idle.sv
module srx_idle #(
  parameter int OVS        = 16,
  parameter int SHORT_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxs,
  input  logic word9,
  input  logic char_done,
  output logic idle_hit
);

  localparam int LIM_S = OVS * SHORT_BITS;
  localparam int LIM_L = OVS * (SHORT_BITS + 1);
  localparam int CW    = $clog2(LIM_L + 1);
  localparam logic [CW-1:0] TOP_S = CW'(LIM_S - 1);
  localparam logic [CW-1:0] TOP_L = CW'(LIM_L - 1);
  localparam logic [CW-1:0] SAT   = CW'(LIM_L);

  logic [CW-1:0] run;
  logic          armed;
  logic [CW-1:0] top;
  logic          seen;

  assign top = word9 ? TOP_L : TOP_S;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= '0;
      armed    <= 1'b0;
      idle_hit <= 1'b0;
    end else begin
      idle_hit <= 1'b0;
      if (tick) begin
        if (!rxs) begin
          run <= '0;
        end else if (run != SAT) begin
          run <= run + 1'b1;
          if (run == top && armed) begin
            idle_hit <= 1'b1;
            armed    <= 1'b0;
          end
        end
      end
      if (char_done) armed <= 1'b1;
    end
  end

  // watch: at most one idle report per received character
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= (seen | idle_hit) & ~char_done;
  end

  AST_IDLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |-> !seen); // R8

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |-> $past(rxs) && $past(tick)); // R7

endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags
  import srx_pkg::*;
#(
  parameter int OVS             = 16,
  parameter int DATA_W          = 9,
  parameter int SHORT_IDLE_BITS = 10,
  parameter int SYNC_STAGES     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rx,
  input  logic              word9,
  input  logic              ie_full,
  input  logic              ie_overrun,
  input  logic              ie_idle,
  input  logic              stat_rd,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              flag_overrun,
  output logic              flag_noise,
  output logic              flag_frame,
  output logic              flag_idle,
  output logic              irq
);

  logic              rxs;
  logic              done;
  logic [DATA_W-1:0] d_data;
  logic              d_noise;
  logic              d_frame;
  logic              idle_hit;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx),
    .dout (rxs)
  );

  srx_deser #(.OVS(OVS), .DATA_W(DATA_W)) u_deser (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick16),
    .rxs    (rxs),
    .word9  (word9),
    .done   (done),
    .dout   (d_data),
    .d_noise(d_noise),
    .d_frame(d_frame)
  );

  srx_idle #(.OVS(OVS), .SHORT_BITS(SHORT_IDLE_BITS)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .rxs      (rxs),
    .word9    (word9),
    .char_done(done),
    .idle_hit (idle_hit)
  );

  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              ovr_q, noise_q, frame_q, idle_q, arm_q;
  logic              take, load, ovr_set, clr;

  always_comb begin
    take    = full_q && out_ready;
    load    = done && (!full_q || take);
    ovr_set = done && full_q && !take;
    clr     = arm_q && out_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      data_q  <= '0;
      ovr_q   <= 1'b0;
      noise_q <= 1'b0;
      frame_q <= 1'b0;
      idle_q  <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      if (load)      full_q <= 1'b1;
      else if (take) full_q <= 1'b0;
      if (load) data_q <= d_data;
      ovr_q   <= (ovr_q   & ~clr) | ovr_set;
      noise_q <= (noise_q & ~clr) | (load & d_noise);
      frame_q <= (frame_q & ~clr) | (load & d_frame);
      idle_q  <= (idle_q  & ~clr) | idle_hit;
      arm_q   <= stat_rd | (arm_q & ~out_ready);
    end
  end

  assign out_valid    = full_q;
  assign out_data     = data_q;
  assign flag_overrun = ovr_q;
  assign flag_noise   = noise_q;
  assign flag_frame   = frame_q;
  assign flag_idle    = idle_q;
  assign irq = (full_q & ie_full) | (ovr_q & ie_overrun) | (idle_q & ie_idle);

  AST_NOISE_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_noise) |-> out_valid && $past(done)); // R3

  AST_FRAME_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_frame) |-> out_valid && $past(done)); // R4

  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data)); // R5

  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && out_valid && !out_ready) |=> flag_overrun && out_valid && $stable(out_data)); // R6

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (out_valid || flag_overrun || flag_idle)); // R9

endmodule

// File: tb/sim_serial_rx_flags.sv
module sim_serial_rx_flags;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] tcnt = 2'd0;
  always @(posedge clk) tcnt <= tcnt + 2'd1;
  wire tick16 = (tcnt == 2'd3);

  logic rx = 1'b1, word9 = 1'b0;
  logic ie_full = 1'b0, ie_overrun = 1'b0, ie_idle = 1'b0;
  logic stat_rd = 1'b0, out_ready = 1'b0;
  logic out_valid, flag_overrun, flag_noise, flag_frame, flag_idle, irq;
  logic [8:0] out_data;

  serial_rx_flags u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx(rx), .word9(word9),
    .ie_full(ie_full), .ie_overrun(ie_overrun), .ie_idle(ie_idle),
    .stat_rd(stat_rd), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .flag_overrun(flag_overrun), .flag_noise(flag_noise),
    .flag_frame(flag_frame), .flag_idle(flag_idle), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!tick16) @(negedge clk);
    end
  endtask

  // one character, 16 ticks per bit; nz = bit index to glitch at its middle sample
  task automatic send(input logic [8:0] d, input bit w9, input int nz, input bit stopv);
    int nb;
    nb = w9 ? 9 : 8;
    tk(1);
    word9 = w9;
    for (int b = 0; b < nb + 2; b++) begin
      logic v;
      if (b == 0)           v = 1'b0;
      else if (b == nb + 1) v = stopv;
      else                  v = d[b-1];
      for (int k = 0; k < 16; k++) begin
        rx = (b == nz && k == 8) ? ~v : v;
        tk(1);
      end
    end
    rx = 1'b1;
  endtask

  task automatic rd_seq();
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) begin stat_rd = 1'b0; out_ready = 1'b1; end
    @(negedge clk) out_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic take_only();
    @(negedge clk) out_ready = 1'b1;
    @(negedge clk) out_ready = 1'b0;
    @(negedge clk);
  endtask

  function automatic int exp_irq(bit f, bit o, bit i, bit ef, bit eo, bit ei);
    return int'((f & ef) | (o & eo) | (i & ei));
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit m_full, m_ovr, m_noise, m_frame;
    logic [8:0] m_data;
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    // R11 reset state
    check("R11 out_valid", out_valid, 0);
    check("R11 flags", {flag_overrun, flag_noise, flag_frame, flag_idle}, 0);
    check("R11 irq", irq, 0);
    rst_n = 1'b1;
    tk(40);

    // R2 short low pulse is not a start bit
    tk(1); rx = 1'b0; tk(5); rx = 1'b1; tk(40);
    check("R2 false start", out_valid, 0);

    // R1 basic 8-bit character
    send(9'h0A5, 0, -1, 1);
    check("R1 valid", out_valid, 1);
    check("R1 data", out_data, 9'h0A5);
    check("R3 no noise", flag_noise, 0);
    tk(20);
    check("R5 valid held", out_valid, 1);
    take_only();
    check("R5 consumed", out_valid, 0);

    // R5 9-bit character
    send(9'h1C3, 1, -1, 1);
    check("R5 nine bit data", out_data, 9'h1C3);
    rd_seq();
    check("R5 cleared", out_valid, 0);

    // R3 noise in data bit, R10 clear needs status read first
    send(9'h03C, 0, 4, 1);
    check("R3 noise data bit", flag_noise, 1);
    check("R3 data intact", out_data, 9'h03C);
    take_only();
    check("R10 take only valid", out_valid, 0);
    check("R10 noise kept", flag_noise, 1);
    rd_seq();
    check("R10 noise cleared", flag_noise, 0);

    // R3 noise in start bit
    send(9'h055, 0, 0, 1);
    check("R3 noise start bit", flag_noise, 1);
    check("R3 start noise data", out_data, 9'h055);
    rd_seq();

    // R4 framing error
    send(9'h081, 0, -1, 0);
    check("R4 frame", flag_frame, 1);
    check("R4 valid", out_valid, 1);
    check("R4 data", out_data, 9'h081);
    rd_seq();
    check("R10 frame cleared", flag_frame, 0);

    // R6 overrun keeps first character, drops second's errors
    send(9'h011, 0, -1, 1);
    send(9'h022, 0, 7, 0);
    check("R6 overrun", flag_overrun, 1);
    check("R6 data kept", out_data, 9'h011);
    check("R6 noise dropped", flag_noise, 0);
    check("R6 frame dropped", flag_frame, 0);
    @(negedge clk) begin ie_overrun = 1'b0; ie_full = 1'b0; end
    @(negedge clk) check("R9 irq masked", irq, 0);
    ie_overrun = 1'b1;
    @(negedge clk) check("R9 irq overrun", irq, 1);
    ie_overrun = 1'b0; ie_full = 1'b1;
    @(negedge clk) check("R9 irq full", irq, 1);
    rd_seq();
    check("R10 overrun cleared", flag_overrun, 0);
    check("R9 irq after clear", irq, 0);
    ie_full = 1'b0;

    // random characters against a model
    m_full = 0; m_ovr = 0; m_noise = 0; m_frame = 0; m_data = '0;
    for (int n = 0; n < 30; n++) begin
      logic [8:0] d;
      bit w9, stopv, rd;
      int nz;
      d = 9'($urandom);
      w9 = 1'($urandom % 2);
      nz = ($urandom % 3 == 0) ? int'($urandom % (w9 ? 11 : 10)) : -1;
      stopv = ($urandom % 5) != 0;
      rd = ($urandom % 4) != 0;
      send(d, w9, nz, stopv);
      if (m_full) m_ovr = 1;
      else begin
        m_full = 1; m_data = w9 ? d : {1'b0, d[7:0]};
        m_noise = (nz >= 0); m_frame = !stopv;
      end
      check("R5 rand valid", out_valid, int'(m_full));
      check("R5 rand data", out_data, int'(m_data));
      check("R6 rand overrun", flag_overrun, int'(m_ovr));
      check("R3 rand noise", flag_noise, int'(m_noise));
      check("R4 rand frame", flag_frame, int'(m_frame));
      ie_full = 1'($urandom); ie_overrun = 1'($urandom);
      @(negedge clk) check("R9 rand irq", irq, exp_irq(m_full, m_ovr, 0, ie_full, ie_overrun, 0));
      if (rd) begin
        rd_seq();
        m_full = 0; m_ovr = 0; m_noise = 0; m_frame = 0;
        check("R10 rand clear", {out_valid, flag_overrun, flag_noise, flag_frame}, 0);
      end
      tk(8);
    end
    ie_full = 1'b0; ie_overrun = 1'b0;

    // idle detection from a fresh reset
    rst_n = 1'b0; tk(2); rst_n = 1'b1;
    tk(200);
    check("R8 disarmed after reset", flag_idle, 0);
    send(9'h035, 0, -1, 1);
    tk(136);
    check("R7 idle early 8-bit", flag_idle, 0);
    tk(16);
    check("R7 idle 8-bit", flag_idle, 1);
    ie_idle = 1'b1;
    @(negedge clk) check("R9 irq idle", irq, 1);
    rd_seq();
    check("R10 idle cleared", flag_idle, 0);
    tk(400);
    check("R8 idle once", flag_idle, 0);
    check("R9 irq idle off", irq, 0);
    ie_idle = 1'b0;
    send(9'h0F0, 1, -1, 1);
    tk(152);
    check("R7 idle early 9-bit", flag_idle, 0);
    tk(16);
    check("R7 idle 9-bit", flag_idle, 1);
    check("R8 rearmed data", out_data, 9'h0F0);
    rd_seq();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule